// File: doc/BRIEF.md
# Peripheral DMA Request Handshake Generator

This block lives inside a peripheral and runs entirely on that peripheral's own clock. It turns the fill state of the peripheral's data FIFO into two handshake outputs for a DMA controller. The first is a burst request. The second is a single-transfer status that shows whether at least one item could move. The block samples the controller's acknowledge on the same clock and uses it to decide when the burst request falls and when it may rise again. The peripheral's clock and the controller's clock are assumed to be phase-aligned, with integer-related frequencies, so no synchronizers are included.

The peripheral selects the direction with a mode input. In destination mode the controller writes into the FIFO, so the free entries are what counts. In source mode the controller reads from the FIFO, so the filled entries are what counts. A programmable burst length sets the threshold for the burst request.

The request is sticky. Once raised, it stays up whatever happens to the level condition until an acknowledge arrives. It then drops at once, even if the condition still holds. It rises again only once the acknowledge has been seen low.

Top module: `dma_hs_gen`

## Requirements
- R1: `burst_req` and `single_rdy` are registered. Each reflects inputs sampled at the previous rising edge of `clk`.
- R2: While `burst_req` is high and `xfer_ack` is low, `burst_req` stays high on the next cycle, even if the level condition has become false.
- R3: When `burst_req` is high and `xfer_ack` is high, `burst_req` is low on the next cycle, even if the level condition is still true.
- R4: When `burst_req` is low, `xfer_ack` is low and the level condition is true, `burst_req` is high on the next cycle. After an acknowledge this makes the earliest re-raise one cycle after the drop.
- R5: While `xfer_ack` is high, a low `burst_req` is not raised.
- R6: With `src_mode` = 0 (destination), the available count is DEPTH minus `fifo_level`.
- R7: With `src_mode` = 1 (source), the available count is `fifo_level`.
- R8: The level condition for a burst is "available count ≥ burst length". A `burst_len` of 0 counts as 1.
- R9: `single_rdy` is high on the cycle after the available count was at least 1, and low otherwise.
- R10: A low `rst_n` at a rising edge clears `burst_req` and `single_rdy`. This reset is synchronous and active low.
- R11: A `fifo_level` above DEPTH is treated as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_mode | input | 1 | 1 = source (controller reads), 0 = destination (controller writes) |
| fifo_level | input | CNT_W | Number of filled FIFO entries |
| burst_len | input | CNT_W | Burst threshold in entries |
| xfer_ack | input | 1 | Acknowledge from the DMA controller |
| burst_req | output | 1 | Burst request to the controller |
| single_rdy | output | 1 | Single-transfer status to the controller |

CNT_W = $clog2(DEPTH+1).

## Verification
The bench builds the block with DEPTH = 8, which gives a 4-bit level input. Level codes 9 to 15 can then be driven, so the clamp is exercised alongside the full and empty boundaries in both directions. Burst lengths of 0, of DEPTH, and in between are all reachable in a few cycles. This short span lets directed sequences place an acknowledge against every request state, and a pseudo-random phase then mixes all the inputs.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic {
        DIR_DEST = 1'b0,
        DIR_SRC  = 1'b1
    } dir_e;

    typedef struct packed {
        logic req;
        logic single;
    } hs_state_t;

endpackage

// File: rtl/dma_hs_level.sv
module dma_hs_level
    import dma_hs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  dir_e             dir,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] blen,
    output logic             burst_ok,
    output logic             single_ok
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] level_c;
    logic [CNT_W-1:0] avail;
    logic [CNT_W-1:0] blen_eff;

    always_comb begin
        level_c  = (level > DEPTH_C) ? DEPTH_C : level;
        avail    = (dir == DIR_SRC) ? level_c : (DEPTH_C - level_c);
        blen_eff = (blen == '0) ? CNT_W'(1) : blen;
        burst_ok = (avail >= blen_eff);
        single_ok = (avail != '0);
    end

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic burst_ok,
    input  logic single_ok,
    input  logic ack,
    output logic req,
    output logic single
);
    hs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.req) begin
            st_d.req = !ack;
        end else begin
            st_d.req = burst_ok && !ack;
        end
        st_d.single = single_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req    = st_q.req;
    assign single = st_q.single;

    a_r2_sticky_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    a_r3_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

    a_r4_raise_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !ack && burst_ok) |=> req);

    a_r5_no_raise_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && ack) |=> !req);

    a_r8_burst_implies_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_ok |-> single_ok);

    a_r9_single_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (single == $past(single_ok)));

endmodule

// File: rtl/dma_hs_gen.sv
module dma_hs_gen
    import dma_hs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_mode,
    input  logic [CNT_W-1:0] fifo_level,
    input  logic [CNT_W-1:0] burst_len,
    input  logic             xfer_ack,
    output logic             burst_req,
    output logic             single_rdy
);
    logic burst_ok;
    logic single_ok;
    dir_e dir;

    assign dir = src_mode ? DIR_SRC : DIR_DEST;

    dma_hs_level #(.DEPTH(DEPTH)) u_level (
        .dir       (dir),
        .level     (fifo_level),
        .blen      (burst_len),
        .burst_ok  (burst_ok),
        .single_ok (single_ok)
    );

    dma_hs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_ok  (burst_ok),
        .single_ok (single_ok),
        .ack       (xfer_ack),
        .req       (burst_req),
        .single    (single_rdy)
    );

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!burst_req && !single_rdy));

endmodule

// File: tb/tb_dma_hs_gen.sv
module tb_dma_hs_gen;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             src_mode = 1'b0;
    logic [CNT_W-1:0] fifo_level = '0;
    logic [CNT_W-1:0] burst_len = '0;
    logic             xfer_ack = 1'b0;
    logic             burst_req;
    logic             single_rdy;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R10 reset";

    logic exp_req = 1'b0;
    logic exp_single = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dma_hs_gen #(.DEPTH(DEPTH)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_mode   (src_mode),
        .fifo_level (fifo_level),
        .burst_len  (burst_len),
        .xfer_ack   (xfer_ack),
        .burst_req  (burst_req),
        .single_rdy (single_rdy)
    );

    // Behavioural reference model of the requirements
    always @(posedge clk) begin
        int lv, av, bl;
        bit ok;
        if (!rst_n) begin
            exp_req    <= 1'b0;                       // R10
            exp_single <= 1'b0;
        end else begin
            lv = int'(fifo_level);
            if (lv > DEPTH) lv = DEPTH;               // R11
            av = src_mode ? lv : DEPTH - lv;          // R6, R7
            bl = (burst_len == 0) ? 1 : int'(burst_len); // R8
            ok = (av >= bl);
            if (exp_req) exp_req <= !xfer_ack;        // R2, R3
            else         exp_req <= ok && !xfer_ack;  // R4, R5
            exp_single <= (av >= 1);                  // R9
        end
    end

    // Compare on every cycle, away from the active edge (R1)
    always @(negedge clk) begin
        if (!done) begin
            n_run++;
            if (burst_req !== exp_req) begin
                n_fail++;
                $display("FAIL %s: burst_req actual=%b expected=%b at %0t",
                         phase, burst_req, exp_req, $time);
            end
            n_run++;
            if (single_rdy !== exp_single) begin
                n_fail++;
                $display("FAIL %s: single_rdy actual=%b expected=%b at %0t",
                         phase, single_rdy, exp_single, $time);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic s, input int lv, input int bl, input logic a);
        src_mode   = s;
        fifo_level = CNT_W'(lv);
        burst_len  = CNT_W'(bl);
        xfer_ack   = a;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        phase = "R10 reset";
        drive(1'b0, 0, 4, 1'b0);
        cyc(3);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R6 destination full";
        drive(1'b0, 8, 4, 1'b0);
        cyc(3);
        phase = "R6 destination three free";
        drive(1'b0, 5, 4, 1'b0);
        cyc(3);
        phase = "R1 R4 destination four free";
        drive(1'b0, 4, 4, 1'b0);
        cyc(3);

        phase = "R2 sticky after condition false";
        drive(1'b0, 8, 4, 1'b0);
        cyc(4);

        phase = "R3 drop on ack";
        drive(1'b0, 0, 4, 1'b1);
        cyc(1);
        phase = "R5 ack held high";
        cyc(3);
        phase = "R4 re-raise after ack low";
        drive(1'b0, 0, 4, 1'b0);
        cyc(3);
        phase = "R3 single-cycle ack then R4 re-raise";
        drive(1'b0, 0, 4, 1'b1);
        cyc(1);
        drive(1'b0, 0, 4, 1'b0);
        cyc(3);

        phase = "R7 source below threshold";
        drive(1'b1, 2, 4, 1'b1);
        cyc(2);
        drive(1'b1, 2, 4, 1'b0);
        cyc(3);
        phase = "R7 source at threshold";
        drive(1'b1, 4, 4, 1'b0);
        cyc(3);
        drive(1'b1, 4, 4, 1'b1);
        cyc(2);

        phase = "R8 zero burst length";
        drive(1'b1, 1, 0, 1'b0);
        cyc(3);
        drive(1'b1, 0, 0, 1'b1);
        cyc(2);
        drive(1'b1, 0, 0, 1'b0);
        cyc(3);
        phase = "R8 burst length equals depth";
        drive(1'b0, 0, 8, 1'b0);
        cyc(3);
        drive(1'b0, 1, 8, 1'b1);
        cyc(1);
        drive(1'b0, 1, 8, 1'b0);
        cyc(3);

        phase = "R9 single in source empty";
        drive(1'b1, 0, 4, 1'b0);
        cyc(2);
        drive(1'b1, 1, 4, 1'b0);
        cyc(2);

        phase = "R11 clamp destination";
        drive(1'b0, 13, 1, 1'b1);
        cyc(2);
        drive(1'b0, 15, 1, 1'b0);
        cyc(3);
        phase = "R11 clamp source";
        drive(1'b1, 12, 8, 1'b0);
        cyc(3);

        phase = "R10 mid-run reset";
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(2);

        phase = "R1 mixed stimulus";
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0], int'(lfsr[4:1]), int'(lfsr[8:5]), lfsr[9] & lfsr[11]);
            cyc(1);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule